// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block feeds a network transmitter from descriptors that software lays out in memory. Each descriptor is four 32-bit words. Word 0 carries an ownership flag and per-frame control bits. Word 1 carries two buffer lengths. Words 2 and 3 carry two buffer addresses. The engine reads a descriptor through a single-outstanding read port and checks that it owns it. It then reads the buffer contents word by word and presents them one byte per handshake on a stream. The stream marks the start and end of each frame and carries the frame's padding and checksum controls.

After a descriptor's buffers are drained, the engine hands the descriptor back to software. It does this by writing word 0 with the ownership flag cleared. It then moves to the next descriptor. The next descriptor is either the next slot of a ring, the ring base after a wrap marker, or the address held in word 3 when linked-list mode is selected. On a descriptor owned by software it stops and waits. A `start` pulse begins at a new ring base. A `poll` pulse retries the descriptor where it stopped.

Top module: `txdf_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_valid`, `wr_valid`, `out_valid` and `irq` are all 0.
- R2: Bit 31 of word 0 set means the engine owns the descriptor. When it reads bit 31 as 0, it emits no bytes, makes no write, and stops issuing reads. A later `poll` pulse refetches that same descriptor, and a `poll` on a still software-owned descriptor produces no output.
- R3: After all buffers of an owned descriptor are drained, word 0 is written back to the descriptor address with bit 31 at 0 and bits 30:0 unchanged. `wr_addr` and `wr_data` stay stable until `wr_ready`.
- R4: Buffer 1 length is word 1 bits 12:0 and buffer 2 length is word 1 bits 28:16. Buffer 1 bytes (address word 2) are streamed before buffer 2 bytes (address word 3).
- R5: A buffer 1 length of 0 skips buffer 1 entirely and proceeds to buffer 2, or to the next descriptor when buffer 2 is absent.
- R6: With word 0 bit 20 set (linked mode), buffer 2 is never streamed whatever word 1 bits 28:16 hold, and the next descriptor is read from the address in word 3.
- R7: Without linked mode, the next descriptor lies 16 bytes after the current one. When word 0 bit 21 is set, the next descriptor is the ring base latched at `start`.
- R8: Buffers may start at any byte address. Memory words are little-endian: the byte at word offset k sits in data bits 8k+7:8k, and bytes leave in ascending address order, crossing word boundaries.
- R9: `out_sof` is 1 on the first byte emitted after a descriptor with word 0 bit 28 is fetched. `out_eof` is 1 on the last byte of a descriptor whose word 0 bit 29 is set.
- R10: If any descriptor of a frame has word 0 bit 30 set, `irq` pulses for exactly one cycle after the write-back handshake of that frame's bit-29 descriptor. Otherwise `irq` stays 0.
- R11: For a frame, `out_no_pad` equals bit 26 of its bit-28 descriptor. `out_no_crc` equals bit 27 AND bit 26 of that descriptor, because an unpadded-disable forces the checksum on.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and the data, sof, eof and flag outputs hold their values.
- R13: A read request holds `rd_valid` and `rd_addr` until `rd_ready`. Descriptor words are read at offsets 0, 4, 8 and 12. Each request waits for its `rsp_valid`, which may come any number of cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch ring base and begin fetching there (idle only) |
| ring_base | input | AW | Address of the first ring descriptor |
| poll | input | 1 | Refetch the current descriptor (idle only) |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Word-aligned read address |
| rd_ready | input | 1 | Read request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data word |
| wr_valid | output | 1 | Write-back request valid |
| wr_addr | output | AW | Write-back address |
| wr_data | output | 32 | Write-back word 0 |
| wr_ready | input | 1 | Write-back accepted |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream byte accepted |
| out_data | output | 8 | Stream byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_no_pad | output | 1 | Frame must not be padded |
| out_no_crc | output | 1 | Frame must not get a checksum |
| irq | output | 1 | One-cycle frame completion pulse |

## Verification
The assertions assume the memory side delivers exactly one `rsp_valid` per accepted read. They also assume it never raises `rsp_valid` when no read is outstanding, and that `start` and `poll` arrive only while the engine is idle. The bench's memory model responds 1 to 3 cycles after each accepted read and only then. The bench pulses `start` and `poll` only after the expected stream and write-backs have all drained. It rewrites descriptors only while the engine sits on a software-owned slot.

// File: rtl/txdf_pkg.sv
`timescale 1ns/1ps
package txdf_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_DREQ, S_DWAIT, S_BSEL, S_BREQ, S_BWAIT, S_BOUT, S_WB
   } st_e;

   // word 0 control bit positions
   localparam int B_OWN   = 31;
   localparam int B_IRQ   = 30;
   localparam int B_LAST  = 29;
   localparam int B_FIRST = 28;
   localparam int B_NOCRC = 27;
   localparam int B_NOPAD = 26;
   localparam int B_WRAP  = 21;
   localparam int B_LINK  = 20;

   // word 1 length fields
   localparam int SZ_W   = 13;
   localparam int SZ1_LO = 0;
   localparam int SZ2_LO = 16;
endpackage

// File: rtl/txdf_byte_pick.sv
`timescale 1ns/1ps
module txdf_byte_pick #(
   parameter  int LANES = 4,
   localparam int OFF_W = $clog2(LANES)
) (
   input  logic [8*LANES-1:0] word,
   input  logic [OFF_W-1:0]   sel,
   output logic [7:0]         byte_o
);
   logic [7:0] lane [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane[g] = word[8*g +: 8];
   end

   assign byte_o = lane[sel];
endmodule

// File: rtl/txdf_next_addr.sv
`timescale 1ns/1ps
module txdf_next_addr #(
   parameter int AW     = 32,
   parameter int STRIDE = 16
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] link,
   input  logic          chain,
   input  logic          wrap,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0] seq;

   assign seq = wrap ? base : cur + AW'(STRIDE);
   assign nxt = chain ? link : seq;
endmodule

// File: rtl/txdf_engine.sv
`timescale 1ns/1ps
module txdf_engine
   import txdf_pkg::*;
#(
   parameter int AW     = 32,
   parameter int STRIDE = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] ring_base,
   input  logic          poll,
   output logic          rd_valid,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ready,
   input  logic          rsp_valid,
   input  logic [31:0]   rsp_data,
   output logic          wr_valid,
   output logic [AW-1:0] wr_addr,
   output logic [31:0]   wr_data,
   input  logic          wr_ready,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [7:0]    out_data,
   output logic          out_sof,
   output logic          out_eof,
   output logic          out_no_pad,
   output logic          out_no_crc,
   output logic          irq
);
   localparam int DW    = 32;
   localparam int LANES = DW / 8;
   localparam int OFF_W = $clog2(LANES);

   if (AW != DW) begin : g_bad_aw
      $error("txdf_engine: AW must equal the 32-bit descriptor address word");
   end
   if (STRIDE < 4 * LANES || (STRIDE % LANES) != 0) begin : g_bad_stride
      $error("txdf_engine: STRIDE must hold four words and be word aligned");
   end

   st_e             st;
   logic [AW-1:0]   cur, base_r, baddr, ptr1, ptr2, nxt;
   logic [30:0]     w0;
   logic [SZ_W-1:0] sz1, sz2, blen;
   logic [1:0]      widx, bsel;
   logic [DW-1:0]   word_r;
   logic            sof_pend, irq_pend, irq_r, npad_r, ncrc_r;
   logic            buf2_on, last_byte, desc_end;
   logic [7:0]      pick;

   assign buf2_on   = !w0[B_LINK] && (sz2 != '0);
   assign last_byte = (blen == SZ_W'(1));
   assign desc_end  = last_byte && ((bsel == 2'd1) || !buf2_on);

   txdf_next_addr #(.AW(AW), .STRIDE(STRIDE)) u_next (
      .cur(cur), .base(base_r), .link(ptr2),
      .chain(w0[B_LINK]), .wrap(w0[B_WRAP]), .nxt(nxt)
   );

   txdf_byte_pick #(.LANES(LANES)) u_pick (
      .word(word_r), .sel(baddr[OFF_W-1:0]), .byte_o(pick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cur      <= '0;
         base_r   <= '0;
         baddr    <= '0;
         ptr1     <= '0;
         ptr2     <= '0;
         w0       <= '0;
         sz1      <= '0;
         sz2      <= '0;
         blen     <= '0;
         widx     <= '0;
         bsel     <= '0;
         word_r   <= '0;
         sof_pend <= 1'b0;
         irq_pend <= 1'b0;
         irq_r    <= 1'b0;
         npad_r   <= 1'b0;
         ncrc_r   <= 1'b0;
      end else begin
         irq_r <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  cur    <= ring_base;
                  base_r <= ring_base;
                  widx   <= '0;
                  st     <= S_DREQ;
               end else if (poll) begin
                  widx <= '0;
                  st   <= S_DREQ;
               end
            end
            S_DREQ: if (rd_ready) st <= S_DWAIT;
            S_DWAIT: begin
               if (rsp_valid) begin
                  unique case (widx)
                     2'd0: w0 <= rsp_data[30:0];
                     2'd1: begin
                        sz1 <= rsp_data[SZ1_LO +: SZ_W];
                        sz2 <= rsp_data[SZ2_LO +: SZ_W];
                     end
                     2'd2: ptr1 <= rsp_data[AW-1:0];
                     default: ptr2 <= rsp_data[AW-1:0];
                  endcase
                  if (widx == 2'd0 && !rsp_data[B_OWN]) begin
                     st <= S_IDLE;
                  end else begin
                     if (widx == 2'd0) begin
                        if (rsp_data[B_FIRST]) begin
                           sof_pend <= 1'b1;
                           npad_r   <= rsp_data[B_NOPAD];
                           ncrc_r   <= rsp_data[B_NOPAD] & rsp_data[B_NOCRC];
                        end
                        if (rsp_data[B_IRQ]) irq_pend <= 1'b1;
                     end
                     if (widx == 2'd3) begin
                        bsel <= '0;
                        st   <= S_BSEL;
                     end else begin
                        widx <= widx + 2'd1;
                        st   <= S_DREQ;
                     end
                  end
               end
            end
            S_BSEL: begin
               unique case (bsel)
                  2'd0: begin
                     if (sz1 != '0) begin
                        baddr <= ptr1;
                        blen  <= sz1;
                        st    <= S_BREQ;
                     end else begin
                        bsel <= 2'd1;
                     end
                  end
                  2'd1: begin
                     if (buf2_on) begin
                        baddr <= ptr2;
                        blen  <= sz2;
                        st    <= S_BREQ;
                     end else begin
                        bsel <= 2'd2;
                     end
                  end
                  default: st <= S_WB;
               endcase
            end
            S_BREQ: if (rd_ready) st <= S_BWAIT;
            S_BWAIT: begin
               if (rsp_valid) begin
                  word_r <= rsp_data;
                  st     <= S_BOUT;
               end
            end
            S_BOUT: begin
               if (out_ready) begin
                  baddr    <= baddr + AW'(1);
                  blen     <= blen - SZ_W'(1);
                  sof_pend <= 1'b0;
                  if (last_byte) begin
                     bsel <= bsel + 2'd1;
                     st   <= S_BSEL;
                  end else if (&baddr[OFF_W-1:0]) begin
                     st <= S_BREQ;
                  end
               end
            end
            S_WB: begin
               if (wr_ready) begin
                  cur  <= nxt;
                  widx <= '0;
                  st   <= S_DREQ;
                  if (w0[B_LAST]) begin
                     irq_r    <= irq_pend;
                     irq_pend <= 1'b0;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign rd_valid   = (st == S_DREQ) || (st == S_BREQ);
   assign rd_addr    = (st == S_DREQ) ? cur + AW'({widx, 2'b00})
                                      : {baddr[AW-1:OFF_W], {OFF_W{1'b0}}};
   assign wr_valid   = (st == S_WB);
   assign wr_addr    = cur;
   assign wr_data    = {1'b0, w0};
   assign out_valid  = (st == S_BOUT);
   assign out_data   = pick;
   assign out_sof    = sof_pend;
   assign out_eof    = desc_end && w0[B_LAST];
   assign out_no_pad = npad_r;
   assign out_no_crc = ncrc_r;
   assign irq        = irq_r;
endmodule

// File: rtl/txdf_engine_chk.sv
`timescale 1ns/1ps
module txdf_engine_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic [AW-1:0] rd_addr,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic [AW-1:0] wr_addr,
   input logic [31:0]   wr_data,
   input logic          out_valid,
   input logic          out_ready,
   input logic [7:0]    out_data,
   input logic          out_sof,
   input logic          out_eof,
   input logic          out_no_pad,
   input logic          out_no_crc,
   input logic          irq
);
   assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof)
         && $stable(out_eof) && $stable(out_no_pad) && $stable(out_no_crc));

   assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

   assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   assert_own_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !wr_data[31]);

   assert_irq_after_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(wr_valid && wr_ready));

   assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

bind txdf_engine txdf_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/txdf_engine_tb.sv
`timescale 1ns/1ps
module txdf_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, poll = 1'b0;
   logic [31:0] ring_base = 32'h100;
   logic        rd_valid, wr_valid, out_valid, irq;
   logic [31:0] rd_addr, wr_addr, wr_data;
   logic        rd_ready = 1'b0, rsp_valid = 1'b0, wr_ready = 1'b0, out_ready = 1'b0;
   logic [31:0] rsp_data = '0;
   logic [7:0]  out_data;
   logic        out_sof, out_eof, out_no_pad, out_no_crc;

   always #2 clk = ~clk;

   txdf_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base), .poll(poll),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_sof(out_sof), .out_eof(out_eof), .out_no_pad(out_no_pad),
      .out_no_crc(out_no_crc), .irq(irq)
   );

   logic [7:0]  mem  [0:4095];
   logic [7:0]  snap [0:4095];
   logic [11:0] byteq [$];
   logic [31:0] wbaq [$];
   logic [31:0] wbdq [$];
   int checks = 0, fails = 0, cyc = 0;
   int exp_irq = 0, got_irq = 0, nbytes = 0, nwb = 0;
   bit m_sof = 0, m_ipend = 0, m_npad = 0, m_ncrc = 0;
   bit took = 0, wtook = 0;
   logic [31:0] taddr, waddr, wdata;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] memw(input logic [31:0] a);
      return {mem[12'(a+3)], mem[12'(a+2)], mem[12'(a+1)], mem[12'(a)]};
   endfunction

   function automatic logic [31:0] snapw(input logic [31:0] a);
      return {snap[12'(a+3)], snap[12'(a+2)], snap[12'(a+1)], snap[12'(a)]};
   endfunction

   task automatic put32(input logic [31:0] a, input logic [31:0] d);
      for (int i = 0; i < 4; i++) mem[12'(a+i)] = d[8*i +: 8];
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] l,
                           input logic [31:0] p1, input logic [31:0] p2);
      put32(a, c); put32(a+4, l); put32(a+8, p1); put32(a+12, p2);
   endtask

   task automatic push_byte(input logic [31:0] a, input bit eof);
      byteq.push_back({m_sof, eof, m_npad, m_ncrc, snap[12'(a)]});
      m_sof = 0;
   endtask

   // reference model: walk descriptors from the requirements
   task automatic build_expect(input logic [31:0] from, input logic [31:0] base);
      logic [31:0] at;
      at = from;
      for (int n = 0; n < 32; n++) begin
         logic [31:0] w0, w1, p1, p2;
         int s1, s2;
         bit b2;
         w0 = snapw(at);
         if (!w0[31]) break;
         w1 = snapw(at+4); p1 = snapw(at+8); p2 = snapw(at+12);
         if (w0[28]) begin m_sof = 1; m_npad = w0[26]; m_ncrc = w0[26] & w0[27]; end
         if (w0[30]) m_ipend = 1;
         s1 = int'(w1[12:0]); s2 = int'(w1[28:16]);
         b2 = !w0[20] && s2 != 0;
         for (int k = 0; k < s1; k++) push_byte(p1 + k, w0[29] && !b2 && k == s1-1);
         if (b2) for (int k = 0; k < s2; k++) push_byte(p2 + k, w0[29] && k == s2-1);
         wbaq.push_back(at);
         wbdq.push_back({1'b0, w0[30:0]});
         snap[12'(at+3)][7] = 1'b0;
         if (w0[29]) begin if (m_ipend) exp_irq++; m_ipend = 0; end
         at = w0[20] ? p2 : (w0[21] ? base : at + 16);
      end
   endtask

   task automatic mem_loop();
      int pend;
      logic [31:0] paddr;
      pend = 0; paddr = '0;
      forever begin
         @(posedge clk); #1;
         rsp_valid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin rsp_valid = 1'b1; rsp_data = memw(paddr); end
         end
         if (took) begin paddr = taddr; pend = 1 + cyc % 3; took = 0; end
         if (wtook) begin put32(waddr, wdata); wtook = 0; end
         rd_ready  = (cyc % 4) != 1;
         out_ready = (cyc % 3) != 2;
         wr_ready  = (cyc % 2) == 0;
      end
   endtask

   task automatic mon_loop();
      bit prd = 0, pout = 0;
      logic [31:0] praddr;
      logic [11:0] pobs, obs, e;
      praddr = '0; pobs = '0;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            obs = {out_sof, out_eof, out_no_pad, out_no_crc, out_data};
            if (prd) chk(rd_valid && rd_addr == praddr, "R13 read request held", rd_addr, praddr);
            if (pout) chk(out_valid && obs == pobs, "R12 stream held", {20'd0, obs}, {20'd0, pobs});
            prd = rd_valid && !rd_ready; praddr = rd_addr;
            pout = out_valid && !out_ready; pobs = obs;
            if (rd_valid && rd_ready) begin took = 1; taddr = rd_addr; end
            if (wr_valid && wr_ready) begin
               wtook = 1; waddr = wr_addr; wdata = wr_data; nwb++;
               if (wbaq.size() == 0) chk(0, "R2 R3 unexpected write-back", wr_addr, 0);
               else begin
                  logic [31:0] ea, ed;
                  ea = wbaq.pop_front(); ed = wbdq.pop_front();
                  chk(wr_addr == ea, "R3 R6 R7 write-back address", wr_addr, ea);
                  chk(wr_data == ed, "R3 write-back word", wr_data, ed);
               end
            end
            if (irq) got_irq++;
            if (out_valid && out_ready) begin
               nbytes++;
               if (byteq.size() == 0) chk(0, "R2 unexpected byte", {20'd0, obs}, 0);
               else begin
                  e = byteq.pop_front();
                  chk(obs == e, "R4 R5 R6 R8 R9 R11 stream byte", {20'd0, obs}, {20'd0, e});
               end
            end
         end
      end
   endtask

   task automatic wait_done();
      while (byteq.size() != 0 || wbaq.size() != 0) @(negedge clk);
      repeat (40) @(negedge clk);
   endtask

   task automatic pulse(input bit is_start);
      @(negedge clk);
      if (is_start) start = 1'b1; else poll = 1'b1;
      @(negedge clk);
      start = 1'b0; poll = 1'b0;
   endtask

   task automatic run_tests();
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
      repeat (4) @(negedge clk);
      chk(!rd_valid && !wr_valid && !out_valid && !irq, "R1 outputs in reset",
          {28'd0, rd_valid, wr_valid, out_valid, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rd_valid && !wr_valid && !out_valid && !irq, "R1 outputs after reset",
          {28'd0, rd_valid, wr_valid, out_valid, irq}, 0);

      // ring: FS+no-pad, skipped buffer 1, LS+irq+wrap; then stop on the wrapped slot
      put_desc(32'h100, 32'h8000_0000 | (1 << 28) | (1 << 26), 5 | (3 << 16), 32'h401, 32'h503);
      put_desc(32'h110, 32'h8000_0000, 0 | (6 << 16), 32'h999, 32'h520);
      put_desc(32'h120, 32'h8000_0000 | (1 << 29) | (1 << 30) | (1 << 21), 7, 32'h542, 0);
      snap = mem;
      build_expect(32'h100, 32'h100);
      pulse(1);
      wait_done();
      chk(byteq.size() == 0 && nbytes == 21, "R4 R5 R7 ring bytes", nbytes, 21);
      chk(nwb == 3, "R7 ring write-backs", nwb, 3);
      chk(got_irq == exp_irq && got_irq == 1, "R10 irq after ring frame", got_irq, 1);
      chk(!rd_valid && memw(32'h100) == 32'h1400_0000, "R2 stop on software-owned", memw(32'h100), 32'h1400_0000);

      // linked list: skip-only head, then FS/LS frame with checksum flag but padding on
      put_desc(32'h100, 32'h8000_0000 | (1 << 20), 0 | (9 << 16), 0, 32'h200);
      put_desc(32'h200, 32'h8000_0000 | (1 << 28) | (1 << 29) | (1 << 30) | (1 << 27) | (1 << 20),
               4 | (5 << 16), 32'h603, 32'h300);
      put_desc(32'h300, 0, 0, 0, 0);
      snap = mem;
      build_expect(32'h100, 32'h100);
      pulse(0);
      wait_done();
      chk(nbytes == 25, "R6 linked mode ignores buffer 2 length", nbytes, 25);
      chk(got_irq == 2, "R10 irq on linked frame", got_irq, 2);
      chk(nwb == 5, "R2 R6 poll restarts at current slot", nwb, 5);

      // word-crossing buffer, both disables, no irq request, links to itself
      put_desc(32'h300, 32'h8000_0000 | (3 << 28) | (1 << 27) | (1 << 26) | (1 << 20),
               3 | (5 << 16), 32'h6FE, 32'h300);
      snap = mem;
      build_expect(32'h300, 32'h100);
      pulse(0);
      wait_done();
      chk(nbytes == 28, "R8 word-crossing buffer", nbytes, 28);
      chk(got_irq == 2, "R10 no irq without request", got_irq, 2);

      // poll while the current slot is still software owned
      pulse(0);
      repeat (40) @(negedge clk);
      chk(nbytes == 28 && nwb == 6 && !rd_valid, "R2 poll on software-owned slot", nbytes, 28);
   endtask

   initial begin
      fork
         mem_loop();
         mon_loop();
         begin
            run_tests();
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
         begin
            repeat (100000) @(posedge clk);
            checks++; fails++;
            $display("FAIL R2 watchdog expired act=%0d exp=0", byteq.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      join_any
   end
endmodule